// File: doc/BRIEF.md
# Serial Clock Generator with Split High/Low Timing

This block makes the serial clock for a serial-port sequencer out of the system clock. A prescaler first divides the system clock by two raised to a 4-bit scale value. A phase timer then counts prescaled ticks to set the time the serial clock spends high and the time it spends low. Each of the two times is set by its own 8-bit length, so the duty cycle need not be 50 %. The polarity input sets the idle level. When it is set, the clock idles high and the waveform is inverted.

The sequencer asks for a burst of edge pairs through a valid/ready request. The request carries the number of pairs. `req_ready` is high only while the generator is idle, enabled and programmed with two nonzero lengths. The request is taken on the cycle where `req_valid` and `req_ready` are both high. While a burst runs, `req_ready` stays low, and the sequencer must hold its request until the burst ends. During the burst the block gives one-cycle strobes for leading and trailing edges, plus a sample strobe picked by the phase input. After the last trailing edge the clock rests at its idle level.

Top module: `sclk_gen`

## Requirements
- R1: After reset `busy` is 0, no strobe is high and `sclk` equals `cpol`.
- R2: `req_ready` is 1 only when the block is idle, `enable` is 1 and both `hi_len` and `lo_len` are nonzero. A request with a nonzero pair count that is taken sets `busy` in the next cycle.
- R3: With scale S, the first leading edge comes 2^S × (idle-half length) system clocks after the acceptance edge. The idle half is the low time when `cpol`=0 and the high time when `cpol`=1. Each later leading edge follows one full period, 2^S × (`hi_len`+`lo_len`), after the one before it.
- R4: `sclk` stays high for `hi_len`×2^S system clocks and low for `lo_len`×2^S system clocks.
- R5: With `cpol`=0 the clock idles low and the leading edge rises. With `cpol`=1 it idles high and the leading edge falls.
- R6: A request for N pairs gives exactly N leading and N trailing strobes. `busy` then drops and `sclk` returns to idle. A request for 0 pairs is consumed and gives no edge.
- R7: `lead_stb` and `trail_stb` are one system clock wide, never high together, and high in the first cycle of the new `sclk` level.
- R8: `sample_stb` marks the rising edges of `sclk` when `cpha`=0 and the falling edges when `cpha`=1.
- R9: A change to `hi_len`, `lo_len` or `scale` during a burst leaves the running half unchanged and applies from the next phase boundary.
- R10: If `enable` goes low, or a length becomes 0, during a burst, `busy` drops in the next cycle and no further strobe follows.
- R11: While `hi_len` or `lo_len` is 0, no request is accepted, and `sclk` holds its idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows generation; dropping it stops a burst |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on rising edges, 1: sample on falling edges |
| scale | input | 4 | Prescale exponent, divide by 2^scale |
| hi_len | input | 8 | High time in prescaled ticks, 0 disables |
| lo_len | input | 8 | Low time in prescaled ticks, 0 disables |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Generator can take a request |
| req_pairs | input | 8 | Number of edge pairs in the burst |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle leading-edge strobe |
| trail_stb | output | 1 | One-cycle trailing-edge strobe |
| sample_stb | output | 1 | One-cycle sample strobe |
| busy | output | 1 | A burst is running |

## Verification
The bench builds the block with its default parameters: a 4-bit scale and an 8-bit pair count. It programs scale values of 0, 2 and 3. With these values, edge times can be predicted both for a prescaler that ticks on every cycle and for one that divides, all within a short run. Both polarities and both phase settings are used, together with lopsided high/low lengths. Edge times are computed from the lengths alone. The runs also cover a mid-burst length change, a mid-burst disable, a zero-pair request and a zero length.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  // Half lengths: the sclk level during a half is active ^ cpol.
  // A high level lasts hi ticks, a low level lasts lo ticks.
  function automatic logic [7:0] half_len(input logic cpol, input logic active,
                                          input logic [7:0] hi, input logic [7:0] lo);
    return (active ^ cpol) ? hi : lo;
  endfunction
endpackage

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  localparam int CNT_W = (1 << SCALE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  // 2^scale - 1. At the top scale the shift wraps to zero and the
  // subtraction gives all ones, which is the right limit.
  assign mask = (CNT_W'(1) << scale) - CNT_W'(1);
  assign tick = run && (cnt == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sclk_sequencer.sv
module sclk_sequencer
  import sclk_gen_pkg::*;
#(
  parameter int SCALE_W = 4,
  parameter int LEN_W   = 8,
  parameter int PAIR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic               tick,
  input  logic               cpol,
  input  logic [SCALE_W-1:0] scale,
  input  logic [LEN_W-1:0]   hi,
  input  logic [LEN_W-1:0]   lo,
  input  logic [PAIR_W-1:0]  pairs,
  output logic               busy,
  output logic               active,
  output logic               cpol_q,
  output logic [SCALE_W-1:0] scale_q,
  output logic               lead_q,
  output logic               trail_q
);
  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  len;
  logic [PAIR_W-1:0] left;
  logic              boundary;

  assign boundary = tick && ({1'b0, cnt} + (LEN_W+1)'(1) == {1'b0, len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      len     <= '0;
      left    <= '0;
      cpol_q  <= 1'b0;
      scale_q <= '0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      if (!busy) begin
        active <= 1'b0;
        if (start && (pairs != '0)) begin
          busy    <= 1'b1;
          cnt     <= '0;
          len     <= half_len(cpol, 1'b0, hi, lo);
          left    <= pairs;
          cpol_q  <= cpol;
          scale_q <= scale;
        end
      end else if (stop) begin
        busy   <= 1'b0;
        active <= 1'b0;
      end else if (boundary) begin
        cnt     <= '0;
        active  <= !active;
        len     <= half_len(cpol_q, !active, hi, lo);
        scale_q <= scale;
        if (!active) begin
          lead_q <= 1'b1;
        end else begin
          trail_q <= 1'b1;
          if (left == PAIR_W'(1)) busy <= 1'b0;
          else                    left <= left - PAIR_W'(1);
        end
      end else if (tick) begin
        cnt <= cnt + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int SCALE_W = 4,
  parameter int LEN_W   = 8,
  parameter int PAIR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [SCALE_W-1:0] scale,
  input  logic [LEN_W-1:0]   hi_len,
  input  logic [LEN_W-1:0]   lo_len,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PAIR_W-1:0]  req_pairs,
  output logic               sclk,
  output logic               lead_stb,
  output logic               trail_stb,
  output logic               sample_stb,
  output logic               busy
);
  logic               cfg_ok;
  logic               accept;
  logic               tick;
  logic               active;
  logic               cpol_q;
  logic               cpha_q;
  logic [SCALE_W-1:0] scale_q;
  logic               rise;
  logic               fall;

  assign cfg_ok    = enable && (hi_len != '0) && (lo_len != '0);
  assign req_ready = !busy && cfg_ok;
  assign accept    = req_valid && req_ready;

  sclk_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .scale (scale_q),
    .tick  (tick)
  );

  sclk_sequencer #(.SCALE_W(SCALE_W), .LEN_W(LEN_W), .PAIR_W(PAIR_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .stop    (!cfg_ok),
    .tick    (tick),
    .cpol    (cpol),
    .scale   (scale),
    .hi      (hi_len),
    .lo      (lo_len),
    .pairs   (req_pairs),
    .busy    (busy),
    .active  (active),
    .cpol_q  (cpol_q),
    .scale_q (scale_q),
    .lead_q  (lead_stb),
    .trail_q (trail_stb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cpha_q <= 1'b0;
    else if (accept) cpha_q <= cpha;
  end

  // Leading edge rises when the clock idles low.
  assign rise       = cpol_q ? trail_stb : lead_stb;
  assign fall       = cpol_q ? lead_stb  : trail_stb;
  assign sample_stb = cpha_q ? fall : rise;
  assign sclk       = busy ? (active ^ cpol_q) : cpol;
endmodule

// File: rtl/sclk_gen_checker.sv
module sclk_gen_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_pairs,
  input logic       sclk,
  input logic       lead_stb,
  input logic       trail_stb,
  input logic       sample_stb,
  input logic       busy
);
  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_stb, trail_stb}));

  assert_lead_on_transition_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != $past(sclk)));

  assert_trail_on_transition_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sclk != $past(sclk)));

  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_pairs != 8'd0)) |=> busy);

  assert_disable_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable) |=> !busy);

  assert_sample_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (lead_stb || trail_stb));
endmodule

bind sclk_gen sclk_gen_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_pairs  (req_pairs),
  .sclk       (sclk),
  .lead_stb   (lead_stb),
  .trail_stb  (trail_stb),
  .sample_stb (sample_stb),
  .busy       (busy)
);

// File: tb/sim_sclk_gen.sv
`timescale 1ns/1ps
module sim_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic [3:0] scale = 4'd0;
  logic [7:0] hi_len = 8'd1;
  logic [7:0] lo_len = 8'd1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_pairs = 8'd0;
  logic       sclk, lead_stb, trail_stb, sample_stb, busy;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int lead_t[32];
  int trail_t[32];
  int samp_t[64];
  logic lead_lvl[32];
  int nl = 0, nt = 0, ns = 0;

  always #2.5 clk = ~clk;

  sclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .scale(scale), .hi_len(hi_len), .lo_len(lo_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_pairs(req_pairs),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb),
    .sample_stb(sample_stb), .busy(busy)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lead_stb) begin
        if (nl < 32) begin lead_t[nl] = cyc; lead_lvl[nl] = sclk; end
        nl++;
      end
      if (trail_stb) begin
        if (nt < 32) trail_t[nt] = cyc;
        nt++;
      end
      if (sample_stb) begin
        if (ns < 64) samp_t[ns] = cyc;
        ns++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clear_log();
    nl = 0; nt = 0; ns = 0;
  endtask

  task automatic issue(input int pairs);
    @(negedge clk);
    req_pairs = pairs[7:0];
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc_cyc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // Full burst with edge times from R3/R4 arithmetic
  task automatic burst(input logic pol, input logic ph, input int sc,
                       input int hi, input int lo, input int pairs, input string tag);
    int unit, idle, actv, lt, tt;
    logic rising_is_lead;
    @(negedge clk);
    cpol = pol; cpha = ph; scale = sc[3:0]; hi_len = hi[7:0]; lo_len = lo[7:0];
    enable = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R2 ready"}, req_ready, 1);
    chk(sclk == pol, {tag, " R5 idle level"}, sclk, pol);
    clear_log();
    issue(pairs);
    chk(busy == 1'b1, {tag, " R2 busy after accept"}, busy, 1);
    wait_idle();
    unit = 1 << sc;
    idle = pol ? hi : lo;
    actv = pol ? lo : hi;
    chk(nl == pairs, {tag, " R6 lead count"}, nl, pairs);
    chk(nt == pairs, {tag, " R6 trail count"}, nt, pairs);
    chk(ns == pairs, {tag, " R8 sample count"}, ns, pairs);
    rising_is_lead = (pol == 1'b0);
    for (int k = 0; k < pairs && k < 32; k++) begin
      lt = acc_cyc + unit * (idle + k * (idle + actv));
      tt = lt + unit * actv;
      chk(lead_t[k] == lt, {tag, " R3 lead time"}, lead_t[k], lt);
      chk(trail_t[k] == tt, {tag, " R4 trail time"}, trail_t[k], tt);
      chk(lead_lvl[k] == !pol, {tag, " R5 level after lead"}, lead_lvl[k], !pol);
      if ((ph == 1'b0) == rising_is_lead)
        chk(samp_t[k] == lt, {tag, " R8 sample at lead"}, samp_t[k], lt);
      else
        chk(samp_t[k] == tt, {tag, " R8 sample at trail"}, samp_t[k], tt);
    end
    chk(sclk == pol, {tag, " R6 back to idle"}, sclk, pol);
    chk(req_ready == 1'b1, {tag, " R2 ready again"}, req_ready, 1);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(lead_stb == 1'b0 && trail_stb == 1'b0 && sample_stb == 1'b0, "R1 strobes",
        {lead_stb, trail_stb, sample_stb}, 0);
    chk(sclk == cpol, "R1 sclk idle", sclk, cpol);
    chk(req_ready == 1'b0, "R2 not ready while disabled", req_ready, 0);
  endtask

  task automatic t_zero_len();
    @(negedge clk);
    enable = 1'b1; cpol = 1'b1; hi_len = 8'd0; lo_len = 8'd3;
    clear_log();
    @(negedge clk);
    chk(req_ready == 1'b0, "R11 ready with hi=0", req_ready, 0);
    req_valid = 1'b1; req_pairs = 8'd2;
    repeat (8) @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b0, "R11 no burst", busy, 0);
    chk(nl + nt == 0, "R11 no strobes", nl + nt, 0);
    chk(sclk == 1'b1, "R11 sclk idle", sclk, 1);
    hi_len = 8'd2; lo_len = 8'd0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R11 ready with lo=0", req_ready, 0);
    lo_len = 8'd2;
  endtask

  task automatic t_zero_pairs();
    @(negedge clk);
    enable = 1'b1; cpol = 1'b0; scale = 4'd0; hi_len = 8'd2; lo_len = 8'd2;
    clear_log();
    issue(0);
    chk(busy == 1'b0, "R6 zero pairs no busy", busy, 0);
    repeat (10) @(negedge clk);
    chk(nl + nt == 0, "R6 zero pairs no edges", nl + nt, 0);
    chk(req_ready == 1'b1, "R6 zero pairs ready", req_ready, 1);
  endtask

  task automatic t_stop();
    @(negedge clk);
    enable = 1'b1; cpol = 1'b0; cpha = 1'b0; scale = 4'd0; hi_len = 8'd4; lo_len = 8'd4;
    clear_log();
    issue(10);
    while (cyc < acc_cyc + 6) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy drops", busy, 0);
    chk(sclk == 1'b0, "R10 sclk idle", sclk, 0);
    repeat (20) @(negedge clk);
    chk(nl == 1, "R10 leads before stop", nl, 1);
    chk(nt == 0, "R10 no trail after stop", nt, 0);
  endtask

  task automatic t_change();
    int a;
    @(negedge clk);
    enable = 1'b1; cpol = 1'b0; cpha = 1'b0; scale = 4'd0; hi_len = 8'd2; lo_len = 8'd2;
    clear_log();
    issue(2);
    a = acc_cyc;
    lo_len = 8'd6;
    wait_idle();
    chk(nl == 2 && nt == 2, "R9 edge count", nl * 10 + nt, 22);
    chk(lead_t[0] == a + 2, "R9 running half kept", lead_t[0], a + 2);
    chk(trail_t[0] == a + 4, "R9 high half", trail_t[0], a + 4);
    chk(lead_t[1] == a + 10, "R9 new low length", lead_t[1], a + 10);
    chk(trail_t[1] == a + 12, "R9 second trail", trail_t[1], a + 12);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    burst(1'b0, 1'b0, 0, 3, 2, 3, "mode0 s0");
    burst(1'b1, 1'b1, 2, 1, 4, 2, "mode3 s2");
    burst(1'b0, 1'b1, 3, 5, 1, 2, "mode1 s3");
    burst(1'b1, 1'b0, 0, 2, 7, 2, "mode2 s0");
    t_zero_len();
    t_zero_pairs();
    t_stop();
    t_change();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule